// File: doc/BRIEF.md
# Gated Square-Wave and One-Shot Generator

A clocked signal source for bench use. A phase accumulator advances by the frequency setting on every system clock and produces a tick on each carry, so the tick rate rises linearly with the setting. Each tick flips a toggle stage, which gives a square wave `q` at half the tick rate with a 50% duty cycle, together with its complement `q_n`. A short delay line on `q` is combined with the undelayed `q` to form a narrow pulse at every rising edge of the square wave.

In astable mode the oscillator runs freely unless it is gated. Gating comes from the active-low remote input `gate_trig_n` or from the push-button once the button has been debounced. While gated, the square wave is held low. When the gate is released, the cycle starts again from a cleared accumulator. In monostable mode the same two inputs act as a trigger. An edge on either one starts a single pulse on `os_q`/`os_q_n` that lasts one full square-wave period at the current setting. Further triggers are ignored until that pulse has ended.

Top module: `sqwave_gen`

## Requirements
- R1: In astable mode with setting F > 0 and no gating, every high and every low level of `q` lasts either floor(2^ACC_W / F) or ceil(2^ACC_W / F) clock cycles. When F divides 2^ACC_W, every level lasts exactly 2^ACC_W / F cycles.
- R2: `q_n` is always the inverse of `q`, and `os_q_n` is always the inverse of `os_q`.
- R3: `pulse` is high for exactly PULSE_W consecutive cycles starting at each rising edge of `q`, as long as the half period is longer than PULSE_W. It is never high while `q` is low.
- R4: In astable mode, if `gate_trig_n` is low or the debounced button is pressed, `q` goes low within 4 cycles (or within DB_CYC+4 cycles for the button) and stays low.
- R5: After the gate is released, the first rising edge of `q` comes between N and N+4 cycles later, where N = ceil(2^ACC_W / F).
- R6: After the 2-stage synchroniser, a change of `button` is accepted only once it has held for DB_CYC consecutive cycles. A shorter press has no effect.
- R7: In monostable mode (`mono_mode` = 1), a falling edge of `gate_trig_n` or a debounced button press raises `os_q`. When F divides 2^ACC_W, `os_q` then stays high for exactly 2^(ACC_W+1) / F cycles.
- R8: In monostable mode, a trigger that arrives while `os_q` is high does not stretch or restart the pulse. `q` and `pulse` stay low in this mode.
- R9: A setting of zero stops the oscillator: `q` stays low and monostable triggers are ignored.
- R10: After reset, `q` = 0, `q_n` = 1, `pulse` = 0, `os_q` = 0 and `os_q_n` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| freq_set | input | ACC_W | Frequency setting, added to the accumulator each cycle |
| mono_mode | input | 1 | 0 = astable, 1 = monostable |
| gate_trig_n | input | 1 | Remote gate (astable) or trigger (monostable), active low, asynchronous |
| button | input | 1 | Manual push-button, active high, raw and bouncing |
| q | output | 1 | Square wave |
| q_n | output | 1 | Complement of `q` |
| pulse | output | 1 | Narrow pulse at each rising edge of `q` |
| os_q | output | 1 | One-shot output |
| os_q_n | output | 1 | Complement of `os_q` |

## Verification
The setting is driven with random values across the full range, plus directed extremes (1, the maximum, and exact powers of two). Measuring each level length against the floor/ceil bounds separates a linear accumulator from one with an inverse or off-by-one relation. The pulse width is measured only at settings where the half period exceeds the delay, so a wrong delay tap shows up as a length error and not as an overlap. One-shot widths are taken at several exact settings and with a trigger repeated in mid-pulse, which separates a period-tied, non-retriggerable timer from one that restarts. Button presses just shorter and well longer than the debounce time show whether debouncing is present.

// File: rtl/sqg_pkg.sv
package sqg_pkg;
    typedef enum logic {
        MODE_ASTABLE = 1'b0,
        MODE_MONO    = 1'b1
    } gen_mode_e;
endpackage

// File: rtl/sqg_sync.sv
module sqg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_val,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = STAGES'({chain_q, din});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{rst_val}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/sqg_debounce.sv
module sqg_debounce #(
    parameter int DB_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CNT_W = $clog2(DB_CYC + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             level;
    } db_t;

    db_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (din != st_q.level) begin
            if (st_q.cnt == CNT_W'(DB_CYC - 1)) begin
                st_d.level = din;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.level;

    // R6: the accepted level only moves toward a differing input sample
    p_db_follows_input_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.level != $past(st_q.level)) |-> ($past(din) != $past(st_q.level)));
endmodule

// File: rtl/sqg_osc.sv
module sqg_osc #(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [ACC_W-1:0] step,
    output logic             tick
);
    logic [ACC_W-1:0] acc_d, acc_q;
    logic [ACC_W:0]   sum;

    always_comb begin
        sum   = {1'b0, acc_q} + {1'b0, step};
        tick  = !clr && sum[ACC_W];
        acc_d = clr ? '0 : sum[ACC_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end
endmodule

// File: rtl/sqwave_gen.sv
module sqwave_gen
    import sqg_pkg::*;
#(
    parameter int ACC_W   = 16,
    parameter int PULSE_W = 3,
    parameter int DB_CYC  = 16,
    parameter int SYNC_N  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] freq_set,
    input  logic             mono_mode,
    input  logic             gate_trig_n,
    input  logic             button,
    output logic             q,
    output logic             q_n,
    output logic             pulse,
    output logic             os_q,
    output logic             os_q_n
);
    typedef struct packed {
        logic               q;
        logic [PULSE_W-1:0] dly;
        logic               os;
        logic               half;
        logic               trig_prev;
    } gen_t;

    gen_t      st_d, st_q;
    gen_mode_e mode;
    logic      gate_s, btn_s, btn_db;
    logic      active, trig, osc_clr, tick;

    sqg_sync #(.STAGES(SYNC_N)) u_sync_gate (
        .clk(clk), .rst_n(rst_n), .rst_val(1'b1), .din(gate_trig_n), .dout(gate_s));

    sqg_sync #(.STAGES(SYNC_N)) u_sync_btn (
        .clk(clk), .rst_n(rst_n), .rst_val(1'b0), .din(button), .dout(btn_s));

    sqg_debounce #(.DB_CYC(DB_CYC)) u_db (
        .clk(clk), .rst_n(rst_n), .din(btn_s), .dout(btn_db));

    sqg_osc #(.ACC_W(ACC_W)) u_osc (
        .clk(clk), .rst_n(rst_n), .clr(osc_clr), .step(freq_set), .tick(tick));

    always_comb begin
        mode    = gen_mode_e'(mono_mode);
        active  = !gate_s || btn_db;
        trig    = active && !st_q.trig_prev;
        osc_clr = (mode == MODE_MONO) ? !st_q.os : active;

        st_d           = st_q;
        st_d.trig_prev = active;
        st_d.dly       = PULSE_W'({st_q.dly, st_q.q});

        if (mode == MODE_ASTABLE) begin
            st_d.os   = 1'b0;
            st_d.half = 1'b0;
            if (active)    st_d.q = 1'b0;
            else if (tick) st_d.q = !st_q.q;
        end else begin
            st_d.q = 1'b0;
            if (!st_q.os) begin
                if (trig && (freq_set != '0)) begin
                    st_d.os   = 1'b1;
                    st_d.half = 1'b0;
                end
            end else if (tick) begin
                if (st_q.half) st_d.os = 1'b0;
                else           st_d.half = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q      = st_q.q;
    assign q_n    = !st_q.q;
    assign pulse  = st_q.q && !st_q.dly[PULSE_W-1];
    assign os_q   = st_q.os;
    assign os_q_n = !st_q.os;

    // R4: a gated astable oscillator leaves the square wave low next cycle
    p_gate_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mono_mode && active) |=> !st_q.q);

    // R8: the square wave is idle in monostable mode
    p_mono_q_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mono_mode |=> !st_q.q);

    // R7: a one-shot starts only from a trigger edge
    p_os_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.os) |-> $past(trig));

    // R7: in monostable mode a one-shot ends only on an oscillator tick
    p_os_end_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(st_q.os) && $past(mono_mode)) |-> $past(tick));
endmodule

// File: tb/tb_sqwave_gen.sv
module tb_sqwave_gen;
    localparam int ACC = 8;
    localparam int ONE = 1 << ACC;
    localparam int PW  = 3;
    localparam int DB  = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [ACC-1:0] freq_set = '0;
    logic           mono_mode = 1'b0;
    logic           gate_trig_n = 1'b1;
    logic           button = 1'b0;
    logic           q, q_n, pulse, os_q, os_q_n;

    int checks = 0;
    int errors = 0;
    int comp_bad = 0;
    int pulse_bad = 0;
    int run = 0;
    int pulse_runs = 0;

    always #5 clk = ~clk;

    sqwave_gen #(.ACC_W(ACC), .PULSE_W(PW), .DB_CYC(DB), .SYNC_N(2)) dut (
        .clk(clk), .rst_n(rst_n), .freq_set(freq_set), .mono_mode(mono_mode),
        .gate_trig_n(gate_trig_n), .button(button),
        .q(q), .q_n(q_n), .pulse(pulse), .os_q(os_q), .os_q_n(os_q_n));

    function automatic int lo_half(int f); return ONE / f; endfunction
    function automatic int hi_half(int f); return (ONE + f - 1) / f; endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic monitor();
        if (q_n !== ~q) comp_bad++;
        if (os_q_n !== ~os_q) comp_bad++;
        if (pulse === 1'b1) begin
            run++;
            if (q !== 1'b1) pulse_bad++;
        end else if (run != 0) begin
            if (run != PW) pulse_bad++;
            pulse_runs++;
            run = 0;
        end
    endtask

    task automatic wait_change(output int n);
        logic prev;
        prev = q;
        n = 0;
        do begin
            @(negedge clk);
            n++;
            monitor();
        end while (q === prev && n < 4000);
    endtask

    task automatic run_astable(input int f);
        int n;
        freq_set = ACC'(f);
        mono_mode = 1'b0;
        gate_trig_n = 1'b1;
        do wait_change(n); while (q !== 1'b0 && n < 4000);
        comp_bad = 0; pulse_bad = 0; run = 0; pulse_runs = 0;
        for (int i = 0; i < 4; i++) begin
            wait_change(n);
            chk(n >= lo_half(f) && n <= hi_half(f), $sformatf("R1 level length F=%0d", f),
                n, hi_half(f));
        end
        chk(comp_bad == 0, "R2 complement outputs", comp_bad, 0);
        if (lo_half(f) > PW)
            chk(pulse_bad == 0 && pulse_runs >= 1, $sformatf("R3 pulse width F=%0d", f),
                pulse_bad, 0);
    endtask

    task automatic os_measure(input int f, input bit use_btn, input bit retrig, output int width);
        int n;
        freq_set = ACC'(f);
        mono_mode = 1'b1;
        repeat (4) @(negedge clk);
        if (use_btn) button = 1'b1; else gate_trig_n = 1'b0;
        n = 0;
        while (os_q !== 1'b1 && n < 200) begin @(negedge clk); n++; end
        if (use_btn) button = 1'b0; else gate_trig_n = 1'b1;
        width = 0;
        while (os_q === 1'b1 && width < 4000) begin
            @(negedge clk);
            width++;
            if (retrig && width == 5) gate_trig_n = 1'b0;
            if (retrig && width == 9) gate_trig_n = 1'b1;
            if (q !== 1'b0 || pulse !== 1'b0) comp_bad++;
        end
        repeat (DB + 6) @(negedge clk);
    endtask

    initial begin
        int n, w, seed;
        seed = $urandom(32'd2024);
        repeat (3) @(negedge clk);
        // R10: reset values
        chk(q == 1'b0 && q_n == 1'b1 && pulse == 1'b0, "R10 reset square outputs", q, 0);
        chk(os_q == 1'b0 && os_q_n == 1'b1, "R10 reset one-shot outputs", os_q, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R3: directed and random settings
        run_astable(1);
        run_astable(64);
        run_astable(255);
        run_astable(37);
        for (int i = 0; i < 8; i++) run_astable(1 + ($urandom % 255));

        // R4: remote gate holds q low
        freq_set = ACC'(20);
        gate_trig_n = 1'b0;
        repeat (4) @(negedge clk);
        n = 0;
        for (int i = 0; i < 300; i++) begin @(negedge clk); if (q !== 1'b0) n++; end
        chk(n == 0, "R4 remote gate holds q low", n, 0);

        // R5: restart after release
        gate_trig_n = 1'b1;
        n = 0;
        while (q !== 1'b1 && n < 1000) begin @(negedge clk); n++; end
        chk(n >= hi_half(20) && n <= hi_half(20) + 4, "R5 restart delay", n, hi_half(20) + 2);

        // R4 R6: debounced button gates astable; short press ignored
        button = 1'b1;
        repeat (DB + 5) @(negedge clk);
        n = 0;
        for (int i = 0; i < 300; i++) begin @(negedge clk); if (q !== 1'b0) n++; end
        chk(n == 0, "R4 button gate holds q low", n, 0);
        button = 1'b0;
        repeat (DB + 5) @(negedge clk);

        // R7 R8: one-shot widths at exact settings
        comp_bad = 0;
        os_measure(32, 1'b0, 1'b0, w);
        chk(w == 2 * ONE / 32, "R7 one-shot width F=32", w, 2 * ONE / 32);
        os_measure(16, 1'b0, 1'b0, w);
        chk(w == 2 * ONE / 16, "R7 one-shot width F=16", w, 2 * ONE / 16);
        os_measure(4, 1'b0, 1'b0, w);
        chk(w == 2 * ONE / 4, "R7 one-shot width F=4", w, 2 * ONE / 4);
        os_measure(8, 1'b0, 1'b1, w);
        chk(w == 2 * ONE / 8, "R8 retrigger ignored", w, 2 * ONE / 8);
        chk(comp_bad == 0, "R8 q and pulse low in monostable", comp_bad, 0);
        os_measure(32, 1'b1, 1'b0, w);
        chk(w == 2 * ONE / 32, "R7 button trigger width", w, 2 * ONE / 32);

        // R6: press shorter than debounce time
        button = 1'b1;
        repeat (DB / 2) @(negedge clk);
        button = 1'b0;
        n = 0;
        for (int i = 0; i < 100; i++) begin @(negedge clk); if (os_q !== 1'b0) n++; end
        chk(n == 0, "R6 short press ignored", n, 0);

        // R9: zero setting
        freq_set = '0;
        gate_trig_n = 1'b0;
        repeat (4) @(negedge clk);
        gate_trig_n = 1'b1;
        n = 0;
        for (int i = 0; i < 100; i++) begin @(negedge clk); if (os_q !== 1'b0) n++; end
        chk(n == 0, "R9 zero setting ignores trigger", n, 0);
        mono_mode = 1'b0;
        n = 0;
        for (int i = 0; i < 600; i++) begin @(negedge clk); if (q !== 1'b0) n++; end
        chk(n == 0, "R9 zero setting stops q", n, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule